// File: doc/BRIEF.md
# Two-Stage Card Clock Divider

This block derives the serial clock for an SD/MMC-style card port from a faster system clock. It runs two cascaded counters. A rate stage produces an enable once every (1 + RATE) system cycles. A phase stage counts those enables and flips the card clock every DIVIDE/2 of them. The card clock therefore runs at the system clock divided by DIVIDE × (1 + RATE), with equal high and low times.

Software writes both settings into one 32-bit timing register. It does this over a single-register write port with byte enables, and it can read the register back at any time. The phase stage is a two-state machine. In ST_LOW the card clock is low; the transition ST_LOW→ST_HIGH (the rising edge) happens when the half-period count wraps. At that moment a one-cycle tick is raised, and the register settings are copied into the active divider settings. In ST_HIGH the card clock is high; the transition ST_HIGH→ST_LOW happens on the next wrap. A setting written in the middle of a period therefore waits for the next rising edge before it takes effect.

Top module: `sdclk_divider`

## Requirements
- R1: The card clock period is DIVIDE × (1 + RATE) system clock cycles, where DIVIDE is bits 15:8 and RATE is bits 7:0 of the timing register.
- R2: The card clock stays high for exactly (DIVIDE/2) × (1 + RATE) cycles, and then stays low for the same number of cycles (50 % duty).
- R3: `reg_rdata` always shows the full 32-bit timing register, and RATE accepts every value from 0 to 255.
- R4: Reset affects the outputs as follows. While `rst_n` is low, the register reads 0x0000_0200 (DIVIDE = 2, RATE = 0), and both `card_clk` and `card_tick` are low. After reset, the card clock runs at half the system clock.
- R5: A write updates only the bytes whose `reg_be` bit is set. A write with `reg_be` = 4'b0011 leaves bits 31:16 unchanged.
- R6: The register stores DIVIDE with bit 8 cleared. If that leaves zero (a write of 0 or 1), the register stores 2 instead. The read-back shows the stored value.
- R7: A setting written during a card clock period takes effect only at the next rising edge of `card_clk`. The period in progress finishes with the old setting, so no runt pulse is produced.
- R8: `card_tick` is high for exactly the one cycle in which `card_clk` has just risen, and it is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the timing register |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current timing register contents |
| card_clk | output | 1 | Divided card clock |
| card_tick | output | 1 | One-cycle pulse on each card clock rise |

## Verification
The default setting checks the tightest case: the rate stage enables every cycle and the clock toggles every cycle. Settings with RATE > 0 and with DIVIDE > 2 are run separately, so a fault in either stage's wrap point shows up apart from the other. Writes issued in the middle of a period show whether the new setting is picked up only at the rising edge. Partial-byte writes, and writes of DIVIDE values that are odd, zero or one, show whether the lane masking and the normalisation behave as specified.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } phase_t;
endpackage

// File: rtl/sdclk_timing_reg.sv
module sdclk_timing_reg #(
    parameter int REG_W      = 32,
    parameter int DIV_W      = 8,
    parameter int RATE_W     = 8,
    parameter int RESET_DIV  = 2,
    parameter int RESET_RATE = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_W/8-1:0]   be,
    input  logic [REG_W-1:0]     wdata,
    output logic [REG_W-1:0]     rdata,
    output logic [DIV_W-1:0]     cfg_div,
    output logic [RATE_W-1:0]    cfg_rate
);
    localparam int NBYTES   = REG_W / 8;
    localparam int RATE_LSB = 0;
    localparam int DIV_LSB  = RATE_LSB + RATE_W;
    localparam logic [REG_W-1:0] RST_VAL =
        (REG_W'(RESET_DIV) << DIV_LSB) | REG_W'(RESET_RATE);

    logic [REG_W-1:0] q, merged, next_q;
    logic [DIV_W-2:0] div_hi;

    // byte-lane merge
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign merged[8*b +: 8] = be[b] ? wdata[8*b +: 8] : q[8*b +: 8];
    end

    // R6: even-only divide, zero treated as 2
    always_comb begin
        div_hi = merged[DIV_LSB+1 +: DIV_W-1];
        next_q = merged;
        if (div_hi == '0)
            next_q[DIV_LSB +: DIV_W] = DIV_W'(2);
        else
            next_q[DIV_LSB +: DIV_W] = {div_hi, 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= RST_VAL;
        else if (wr_en)
            q <= next_q;
    end

    assign rdata    = q;
    assign cfg_div  = q[DIV_LSB +: DIV_W];
    assign cfg_rate = q[RATE_LSB +: RATE_W];

    p_div_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_div[0] == 1'b0) && (cfg_div != '0));

    p_top_lane_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !be[NBYTES-1]) |=> $stable(rdata[REG_W-1 -: 8]));
endmodule

// File: rtl/sdclk_rate_stage.sv
module sdclk_rate_stage #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] act_rate,
    output logic              en
);
    logic [RATE_W-1:0] cnt_q;

    assign en = (cnt_q == act_rate);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (en)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + RATE_W'(1);
    end

    p_rate_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= act_rate);
endmodule

// File: rtl/sdclk_phase_fsm.sv
module sdclk_phase_fsm
    import sdclk_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int RATE_W     = 8,
    parameter int RESET_DIV  = 2,
    parameter int RESET_RATE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [RATE_W-1:0] cfg_rate,
    output logic [RATE_W-1:0] act_rate,
    output logic              card_clk,
    output logic              card_tick
);
    localparam int HALF_W = DIV_W - 1;

    phase_t            state_q, state_d;
    logic [HALF_W-1:0] half_q, act_half_q;
    logic [RATE_W-1:0] act_rate_q;
    logic              wrap, rise, tick_q;

    assign wrap = en && (half_q == act_half_q - HALF_W'(1));
    assign rise = wrap && (state_q == ST_LOW);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW:  if (wrap) state_d = ST_HIGH;
            ST_HIGH: if (wrap) state_d = ST_LOW;
        endcase
    end

    // state register, half-period counter, active settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_LOW;
            half_q     <= '0;
            act_half_q <= HALF_W'(RESET_DIV / 2);
            act_rate_q <= RATE_W'(RESET_RATE);
        end else begin
            state_q <= state_d;
            if (wrap)
                half_q <= '0;
            else if (en)
                half_q <= half_q + HALF_W'(1);
            if (rise) begin
                act_half_q <= cfg_div[DIV_W-1:1];
                act_rate_q <= cfg_rate;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tick_q <= 1'b0;
        else
            tick_q <= rise;
    end

    assign card_clk  = (state_q == ST_HIGH);
    assign card_tick = tick_q;
    assign act_rate  = act_rate_q;

    p_half_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        half_q < act_half_q);

    p_load_at_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> ($stable(act_half_q) && $stable(act_rate_q)));
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider #(
    parameter int REG_W      = 32,
    parameter int DIV_W      = 8,
    parameter int RATE_W     = 8,
    parameter int RESET_DIV  = 2,
    parameter int RESET_RATE = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [REG_W/8-1:0] reg_be,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               card_clk,
    output logic               card_tick
);
    logic [DIV_W-1:0]  cfg_div;
    logic [RATE_W-1:0] cfg_rate, act_rate;
    logic              en;

    sdclk_timing_reg #(
        .REG_W(REG_W), .DIV_W(DIV_W), .RATE_W(RATE_W),
        .RESET_DIV(RESET_DIV), .RESET_RATE(RESET_RATE)
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .be(reg_be),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .cfg_div(cfg_div), .cfg_rate(cfg_rate)
    );

    sdclk_rate_stage #(.RATE_W(RATE_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .act_rate(act_rate), .en(en)
    );

    sdclk_phase_fsm #(
        .DIV_W(DIV_W), .RATE_W(RATE_W),
        .RESET_DIV(RESET_DIV), .RESET_RATE(RESET_RATE)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .en(en),
        .cfg_div(cfg_div), .cfg_rate(cfg_rate), .act_rate(act_rate),
        .card_clk(card_clk), .card_tick(card_tick)
    );

    p_tick_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        card_tick |-> (card_clk && !$past(card_clk)));

    p_rise_has_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_clk) |-> card_tick);
endmodule

// File: tb/sdclk_divider_tb.sv
module sdclk_divider_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        card_clk, card_tick;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string phase_req = "R4";

    always #(CLK_PERIOD/2) clk = ~clk;

    sdclk_divider u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .card_clk(card_clk), .card_tick(card_tick)
    );

    // behavioural reference model
    logic [31:0] m_reg;
    bit          m_clk, m_tick;
    int          m_cnt, m_half;

    function automatic logic [31:0] apply_write(logic [31:0] old,
                                                logic [3:0] be, logic [31:0] d);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++)
            if (be[b]) r[8*b +: 8] = d[8*b +: 8];
        if (r[15:8] < 8'd2) r[15:8] = 8'd2;
        else r[8] = 1'b0;
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_reg = 32'h0000_0200; m_clk = 0; m_tick = 0; m_cnt = 0; m_half = 1;
        end else begin
            m_tick = 0;
            m_cnt++;
            if (m_cnt == m_half) begin
                m_cnt = 0;
                m_clk = !m_clk;
                if (m_clk) begin
                    m_tick = 1;
                    m_half = (int'(m_reg[15:8]) / 2) * (1 + int'(m_reg[7:0]));
                end
            end
            if (reg_wr) m_reg = apply_write(m_reg, reg_be, reg_wdata);
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(phase_req, "card_clk", 32'(card_clk), 32'(m_clk));
            check("R8", "card_tick", 32'(card_tick), 32'(m_tick));
            check("R3", "reg_rdata", reg_rdata, m_reg);
        end
    end

    task automatic wr(logic [3:0] be, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R4: reset values
        check("R4", "reset rdata", reg_rdata, 32'h0000_0200);
        check("R4", "reset card_clk", 32'(card_clk), 32'd0);
        check("R4", "reset card_tick", 32'(card_tick), 32'd0);
        rst_n = 1'b1;
        phase_req = "R4";
        repeat (20) @(negedge clk);

        phase_req = "R1";                       // D=4, R=3
        wr(4'hF, 32'hABCD_0403);
        repeat (100) @(negedge clk);

        phase_req = "R2";                       // D=8, R=2
        wr(4'hF, 32'hABCD_0802);
        repeat (150) @(negedge clk);

        phase_req = "R7";                       // mid-period changes
        repeat (5) @(negedge clk);
        wr(4'hF, 32'hABCD_0601);
        repeat (3) @(negedge clk);
        wr(4'hF, 32'hABCD_0200);
        repeat (80) @(negedge clk);

        phase_req = "R5";                       // low half only
        wr(4'b0011, 32'h1234_0A00);
        check("R5", "upper half kept", {16'h0, reg_rdata[31:16]}, 32'h0000_ABCD);
        repeat (60) @(negedge clk);

        phase_req = "R6";                       // odd, zero, one
        wr(4'b0010, 32'h0000_0700);
        check("R6", "odd divide", {24'h0, reg_rdata[15:8]}, 32'd6);
        repeat (60) @(negedge clk);
        wr(4'b0010, 32'h0000_0000);
        check("R6", "zero divide", {24'h0, reg_rdata[15:8]}, 32'd2);
        repeat (30) @(negedge clk);
        wr(4'b0010, 32'h0000_0100);
        check("R6", "one divide", {24'h0, reg_rdata[15:8]}, 32'd2);
        repeat (30) @(negedge clk);

        phase_req = "R3";                       // maximum rate
        wr(4'b0001, 32'h0000_00FF);
        check("R3", "rate field", {24'h0, reg_rdata[7:0]}, 32'hFF);
        repeat (1300) @(negedge clk);

        phase_req = "R1";                       // large divide
        wr(4'hF, 32'h0000_FE01);
        repeat (1600) @(negedge clk);

        finish_run();
    end
endmodule